// File: doc/BRIEF.md
# Instruction Decode and ALU Unit

This combinational unit takes one 32-bit instruction word and two register operand values. It decodes a small integer subset and produces the 32-bit result in the same cycle. The subset covers register-register add, subtract, OR, XOR and the three shifts, the immediate forms of add, AND and OR, and load-upper-immediate.

Alongside the result, the unit sends out three register indices taken from the instruction: the destination and the two sources. It also drives a write enable for the destination register. Any encoding outside the subset raises an illegal-instruction flag and suppresses the write. Loads, stores, branches, jumps, multiply and divide are not decoded. The register file and the program counter stay outside this block.

Internally, a control decoder turns the opcode (bits 6..0), funct3 (bits 14..12) and funct7 (bits 31..25) into a small set of strobes. A datapath uses those strobes to build the immediate, choose the second operand and run the arithmetic.

Top module: `idalu_unit`

## Requirements
- R1: The destination index is instruction bits 11..7, the first source index is bits 19..15 and the second source index is bits 24..20, for every instruction word, legal or not.
- R2: With opcode 0110011 and funct3 000, funct7 0000000 gives opA+opB and funct7 0100000 gives opA-opB, both modulo 2^32.
- R3: With opcode 0110011 and funct7 0000000, funct3 110 gives opA|opB and funct3 100 gives opA^opB.
- R4: With opcode 0110011, funct3 001 with funct7 0000000 shifts opA left, filling with zeros. Funct3 101 with funct7 0000000 shifts opA right, filling with zeros. Funct3 101 with funct7 0100000 shifts opA right, filling with copies of bit 31. All three shift by opB bits 4..0 alone.
- R5: With opcode 0010011 and funct3 000, the result is opA plus instruction bits 31..20, sign-extended from bit 31.
- R6: With opcode 0010011, funct3 111 gives opA AND the zero-extended bits 31..20, and funct3 110 gives opA OR the zero-extended bits 31..20.
- R7: With opcode 0110111, result bits 31..12 equal instruction bits 31..12 and result bits 11..0 are zero, whatever the operands.
- R8: Every other combination of opcode, funct3 and funct7 sets the illegal flag to 1, the write enable to 0 and the result to zero.
- R9: Every instruction in the subset sets the write enable to 1 and the illegal flag to 0, including one whose destination index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| opA | input | 32 | Value of the first source register |
| opB | input | 32 | Value of the second source register |
| resultOut | output | 32 | Computed result, zero when the encoding is illegal |
| rdIdx | output | 5 | Destination register index |
| rs1Idx | output | 5 | First source register index |
| rs2Idx | output | 5 | Second source register index |
| regWriteEn | output | 1 | Destination write enable |
| illegalInstr | output | 1 | Encoding lies outside the subset |

## Verification
The assertions assume that the instruction word and both operands are fully driven, with no unknown bits, whenever they are evaluated. They also assume the operands are the values the source indices select, but no assertion relies on that link. The bench drives known values on every input from time zero and changes them only just after a rising clock edge. It mixes hand-built legal encodings that have random fields and operands with fully random words, so the illegal paths are reached as well.

// File: rtl/idalu_pkg.sv
package idalu_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int OPC_W = 7;
  localparam int F3_W = 3;
  localparam int F7_W = 7;

  localparam logic [OPC_W-1:0] OPC_REGREG = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMMOP  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_UPPER  = 7'b0110111;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_OR, ALU_XOR, ALU_AND,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
  } aluOpE;

  typedef enum logic [1:0] {
    IMM_NONE, IMM_SEXT12, IMM_ZEXT12, IMM_UPPER20
  } immKindE;

  typedef struct packed {
    aluOpE   aluOp;
    immKindE immKind;
    logic    useImm;
    logic    writeEn;
    logic    illegal;
  } ctrlS;
endpackage

// File: rtl/idalu_ctrl.sv
module idalu_ctrl
  import idalu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [F3_W-1:0]  funct3,
  input  logic [F7_W-1:0]  funct7,
  output ctrlS             ctrl
);
  logic  legal;
  aluOpE op;
  immKindE immK;

  always_comb begin
    legal = 1'b0;
    op    = ALU_ADD;
    immK  = IMM_NONE;
    unique case (opcode)
      OPC_REGREG: begin
        if (funct7 == F7_BASE) begin
          legal = 1'b1;
          case (funct3)
            3'b000:  op = ALU_ADD;
            3'b110:  op = ALU_OR;
            3'b100:  op = ALU_XOR;
            3'b001:  op = ALU_SLL;
            3'b101:  op = ALU_SRL;
            default: legal = 1'b0;
          endcase
        end else if (funct7 == F7_ALT) begin
          legal = 1'b1;
          case (funct3)
            3'b000:  op = ALU_SUB;
            3'b101:  op = ALU_SRA;
            default: legal = 1'b0;
          endcase
        end
      end
      OPC_IMMOP: begin
        legal = 1'b1;
        case (funct3)
          3'b000: begin op = ALU_ADD; immK = IMM_SEXT12; end
          3'b111: begin op = ALU_AND; immK = IMM_ZEXT12; end
          3'b110: begin op = ALU_OR;  immK = IMM_ZEXT12; end
          default: legal = 1'b0;
        endcase
      end
      OPC_UPPER: begin
        legal = 1'b1;
        op    = ALU_PASSB;
        immK  = IMM_UPPER20;
      end
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.aluOp   = op;
    ctrl.immKind = immK;
    ctrl.useImm  = (immK != IMM_NONE);
    ctrl.writeEn = legal;
    ctrl.illegal = !legal;
  end
endmodule

// File: rtl/idalu_datapath.sv
module idalu_datapath
  import idalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctrlS             ctrl,
  input  logic [31:12]     immField,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  output logic [XLEN-1:0]  result
);
  localparam int SHW = $clog2(XLEN);
  localparam int IMM12_PAD = XLEN - 12;
  localparam int UP_PAD = XLEN - 20;

  logic [XLEN-1:0] immVal;
  logic [XLEN-1:0] srcB;
  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] aluOut;

  always_comb begin
    unique case (ctrl.immKind)
      IMM_SEXT12:  immVal = {{IMM12_PAD{immField[31]}}, immField[31:20]};
      IMM_ZEXT12:  immVal = {{IMM12_PAD{1'b0}}, immField[31:20]};
      IMM_UPPER20: immVal = {immField[31:12], {UP_PAD{1'b0}}};
      default:     immVal = '0;
    endcase
  end

  assign srcB  = ctrl.useImm ? immVal : opB;
  assign shamt = srcB[SHW-1:0];

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD:   aluOut = opA + srcB;
      ALU_SUB:   aluOut = opA - srcB;
      ALU_OR:    aluOut = opA | srcB;
      ALU_XOR:   aluOut = opA ^ srcB;
      ALU_AND:   aluOut = opA & srcB;
      ALU_SLL:   aluOut = opA << shamt;
      ALU_SRL:   aluOut = opA >> shamt;
      ALU_SRA:   aluOut = $unsigned($signed(opA) >>> shamt);
      ALU_PASSB: aluOut = srcB;
      default:   aluOut = '0;
    endcase
  end

  assign result = ctrl.illegal ? '0 : aluOut;
endmodule

// File: rtl/idalu_unit.sv
module idalu_unit
  import idalu_pkg::*;
(
  input  logic [31:0] instrWord,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] resultOut,
  output logic [4:0]  rdIdx,
  output logic [4:0]  rs1Idx,
  output logic [4:0]  rs2Idx,
  output logic        regWriteEn,
  output logic        illegalInstr
);
  ctrlS ctrl;

  idalu_ctrl u_ctrl (
    .opcode (instrWord[6:0]),
    .funct3 (instrWord[14:12]),
    .funct7 (instrWord[31:25]),
    .ctrl   (ctrl)
  );

  idalu_datapath #(.XLEN(32)) u_dp (
    .ctrl     (ctrl),
    .immField (instrWord[31:12]),
    .opA      (opA),
    .opB      (opB),
    .result   (resultOut)
  );

  assign rdIdx        = instrWord[11:7];
  assign rs1Idx       = instrWord[19:15];
  assign rs2Idx       = instrWord[24:20];
  assign regWriteEn   = ctrl.writeEn;
  assign illegalInstr = ctrl.illegal;
endmodule

// File: rtl/idalu_checker.sv
module idalu_checker (
  input logic [31:0] instrWord,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] resultOut,
  input logic        regWriteEn,
  input logic        illegalInstr
);
  logic known;
  assign known = !$isunknown({instrWord, opA, opB});

  always_comb begin
    if (known) begin
      // R8 / R9: exactly one of write enable and illegal flag is high
      p_we_vs_illegal_r9: assert (regWriteEn != illegalInstr)
        else $error("write enable and illegal flag agree");
      // R8: illegal encodings give a zero result
      p_illegal_zero_r8: assert (!illegalInstr || resultOut == 32'h0)
        else $error("illegal encoding with nonzero result");
      // R7: upper immediate lands high, low 12 bits clear
      p_upper_imm_r7: assert (instrWord[6:0] != 7'b0110111 ||
                              (resultOut[11:0] == 12'h0 &&
                               resultOut[31:12] == instrWord[31:12]))
        else $error("upper immediate result malformed");
      // R6: AND with zero-extended immediate leaves high bits clear
      p_andi_high_clear_r6: assert (!(instrWord[6:0] == 7'b0010011 &&
                                      instrWord[14:12] == 3'b111) ||
                                    resultOut[31:12] == 20'h0)
        else $error("AND immediate set high bits");
      // R3: register OR keeps every bit set in opA
      p_or_covers_r3: assert (!(instrWord[6:0] == 7'b0110011 &&
                                instrWord[14:12] == 3'b110 &&
                                instrWord[31:25] == 7'b0) ||
                              (resultOut & opA) == opA)
        else $error("OR result lost a bit of opA");
      // R4: left shift of one uses only the low five bits of opB
      p_sll_amount_r4: assert (!(instrWord[6:0] == 7'b0110011 &&
                                 instrWord[14:12] == 3'b001 &&
                                 instrWord[31:25] == 7'b0 &&
                                 opA == 32'h1) ||
                               $countones(resultOut) == 1)
        else $error("shift of one not a single bit");
    end
  end
endmodule

bind idalu_unit idalu_checker u_chk (
  .instrWord    (instrWord),
  .opA          (opA),
  .opB          (opB),
  .resultOut    (resultOut),
  .regWriteEn   (regWriteEn),
  .illegalInstr (illegalInstr)
);

// File: tb/sim_idalu_unit.sv
`timescale 1ns/1ps
module sim_idalu_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instrWord = 32'h0, opA = 32'h0, opB = 32'h0;
  logic [31:0] resultOut;
  logic [4:0]  rdIdx, rs1Idx, rs2Idx;
  logic        regWriteEn, illegalInstr;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  idalu_unit u0 (.*);

  function automatic logic [31:0] mkR(input logic [6:0] f7, input logic [4:0] s2,
      input logic [4:0] s1, input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {f7, s2, s1, f3, d, op};
  endfunction

  function automatic logic [31:0] mkI(input logic [11:0] imm, input logic [4:0] s1,
      input logic [2:0] f3, input logic [4:0] d);
    return {imm, s1, f3, d, 7'b0010011};
  endfunction

  // Behavioural model written from the requirements
  task automatic refModel(input logic [31:0] iw, a, b,
      output logic [31:0] r, output logic we, output logic ill);
    logic ok;
    logic [31:0] sx, zx;
    ok = 1'b0; r = 32'h0;
    sx = {{20{iw[31]}}, iw[31:20]};
    zx = {20'h0, iw[31:20]};
    if (iw[6:0] == 7'b0110011) begin
      if (iw[31:25] == 7'h00) begin
        ok = 1'b1;
        case (iw[14:12])
          3'd0: r = a + b;
          3'd6: r = a | b;
          3'd4: r = a ^ b;
          3'd1: r = a << b[4:0];
          3'd5: r = a >> b[4:0];
          default: ok = 1'b0;
        endcase
      end else if (iw[31:25] == 7'h20) begin
        ok = 1'b1;
        case (iw[14:12])
          3'd0: r = a - b;
          3'd5: r = $unsigned($signed(a) >>> b[4:0]);
          default: ok = 1'b0;
        endcase
      end
    end else if (iw[6:0] == 7'b0010011) begin
      ok = 1'b1;
      case (iw[14:12])
        3'd0: r = a + sx;
        3'd7: r = a & zx;
        3'd6: r = a | zx;
        default: ok = 1'b0;
      endcase
    end else if (iw[6:0] == 7'b0110111) begin
      ok = 1'b1;
      r = {iw[31:12], 12'h0};
    end
    if (!ok) r = 32'h0;
    we = ok;
    ill = !ok;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Apply one vector just after a rising edge, compare at the falling edge
  task automatic apply(input string tag, input logic [31:0] iw, a, b);
    logic [31:0] er;
    logic ew, ei;
    @(posedge clk);
    #1;
    instrWord = iw; opA = a; opB = b;
    @(negedge clk);
    refModel(iw, a, b, er, ew, ei);
    chk(tag, "result", resultOut, er);
    chk((ei ? "R8" : "R9"), "writeEn", {31'h0, regWriteEn}, {31'h0, ew});
    chk((ei ? "R8" : "R9"), "illegal", {31'h0, illegalInstr}, {31'h0, ei});
    chk("R1", "fields", {17'h0, rdIdx, rs1Idx, rs2Idx}, {17'h0, iw[11:7], iw[19:15], iw[24:20]});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // reset state: all-zero word is illegal (R8)
    @(negedge clk);
    chk("R8", "initial result", resultOut, 32'h0);
    chk("R8", "initial illegal", {31'h0, illegalInstr}, 32'h1);

    apply("R2", mkR(7'h00, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33), 32'hFFFF_FFFF, 32'h2);
    apply("R2", mkR(7'h20, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33), 32'h5, 32'h7);
    apply("R3", mkR(7'h00, 5'd4, 5'd5, 3'd6, 5'd6, 7'h33), 32'hF0F0_0000, 32'h0F0F_1234);
    apply("R3", mkR(7'h00, 5'd4, 5'd5, 3'd4, 5'd6, 7'h33), 32'hAAAA_5555, 32'hFFFF_0000);
    apply("R4", mkR(7'h00, 5'd1, 5'd2, 3'd1, 5'd3, 7'h33), 32'h1, 32'hFFFF_FFE4);
    apply("R4", mkR(7'h00, 5'd1, 5'd2, 3'd5, 5'd3, 7'h33), 32'h8000_0000, 32'h0000_0021);
    apply("R4", mkR(7'h20, 5'd1, 5'd2, 3'd5, 5'd3, 7'h33), 32'h8000_0000, 32'h0000_003F);
    apply("R5", mkI(12'hFFF, 5'd7, 3'd0, 5'd8), 32'h10, 32'h0);
    apply("R5", mkI(12'h7FF, 5'd7, 3'd0, 5'd8), 32'h1, 32'h0);
    apply("R6", mkI(12'hF0F, 5'd7, 3'd7, 5'd8), 32'hFFFF_FFFF, 32'h0);
    apply("R6", mkI(12'h800, 5'd7, 3'd6, 5'd8), 32'h1234_0000, 32'h0);
    apply("R7", {20'hABCDE, 5'd9, 7'b0110111}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R9", mkR(7'h00, 5'd1, 5'd2, 3'd0, 5'd0, 7'h33), 32'h3, 32'h4);
    apply("R8", mkR(7'h01, 5'd1, 5'd2, 3'd0, 5'd3, 7'h33), 32'h3, 32'h4);
    apply("R8", mkR(7'h20, 5'd1, 5'd2, 3'd6, 5'd3, 7'h33), 32'h3, 32'h4);
    apply("R8", mkR(7'h00, 5'd1, 5'd2, 3'd7, 5'd3, 7'h33), 32'h3, 32'h4);
    apply("R8", mkI(12'h123, 5'd1, 3'd2, 5'd3), 32'h3, 32'h4);
    apply("R8", 32'h0000_0003, 32'h3, 32'h4);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [2:0] kind;
      logic [2:0] f3;
      logic [6:0] f7;
      kind = 3'($urandom_range(0, 4));
      f3 = 3'($urandom);
      f7 = ($urandom_range(0, 1) == 0) ? 7'h00 : 7'h20;
      case (kind)
        3'd0: w = mkR(f7, 5'($urandom), 5'($urandom), f3, 5'($urandom), 7'h33);
        3'd1: w = mkI(12'($urandom), 5'($urandom), f3, 5'($urandom));
        3'd2: w = {20'($urandom), 5'($urandom), 7'b0110111};
        default: w = $urandom;
      endcase
      apply("R2-R8 mix", w, $urandom, $urandom);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule